// File: doc/BRIEF.md
# Two-Port Bank-Interleaved Data Cache Arbiter

This block makes a data cache built from eight single-ported storage banks look as if it had two independent load/store ports. Each cycle up to two requests arrive, one per port, each carrying a byte address, a write flag and write data. The block works out which bank each request addresses. When the two banks differ, it grants both requests and steers each one to its bank in the same cycle. When both requests address the same bank, only one request goes through and the other is held back.

The bank is chosen by the doubleword address bits, so sequential 8-byte accesses walk across all eight banks. This makes collisions rare for streaming code. On a collision port 0 normally wins. A port 1 request that was refused in one cycle wins the next collision, so neither port can be starved. Every bank access carries a one-bit tag naming the port it serves. A bank answers a read one cycle after the access, and the block delivers that data on the response output of the port that asked for it.

Both request ports use valid/ready handshakes. A request is accepted at a rising clock edge where valid and ready are both high. A port whose request is refused must hold valid, address, write flag and data stable until the request is accepted. Ready is a function of the current requests and of whether port 1 was refused in the previous cycle, and it may be low while valid is low. The response outputs have no ready signal and cannot be back-pressured: the consumer must take the data in the cycle it is valid.

Top module: `cbank_dual_arb`

## Requirements
- R1: The bank number of a request is address bits [5:3]. The row index sent to the bank is address bits [15:6]. Address bits [2:0] are ignored.
- R2: When both ports are valid and address different banks, both ready outputs are high in that cycle.
- R3: When both ports are valid and address the same bank, and port 1 was not refused in the previous cycle, port 0 ready is high and port 1 ready is low.
- R4: When port 1 was valid and refused in the previous cycle and the two valid ports now address the same bank, port 1 ready is high and port 0 ready is low.
- R5: A bank enable bit is high exactly for the banks of the requests accepted in that cycle. The number of enabled banks equals the number of accepted requests, and a port whose valid is low drives no bank.
- R6: An enabled bank receives the accepted request's write flag, row index and write data. Its port tag is 0 for port 0 and 1 for port 1.
- R7: A read accepted on a port raises that port's response valid in the next cycle. The response data is then the read data of the bank the read went to. In any other cycle the port's response valid is low, and an accepted write gives no response.
- R8: While reset (active low) is asserted and in the first cycle after it, both response valids are low and no collision preference is held for port 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| p0_valid | input | 1 | Port 0 request valid |
| p0_ready | output | 1 | Port 0 request accepted this cycle if valid |
| p0_addr | input | 16 | Port 0 byte address |
| p0_we | input | 1 | Port 0 write flag (1 = store) |
| p0_wdata | input | 64 | Port 0 store data |
| p1_valid | input | 1 | Port 1 request valid |
| p1_ready | output | 1 | Port 1 request accepted this cycle if valid |
| p1_addr | input | 16 | Port 1 byte address |
| p1_we | input | 1 | Port 1 write flag (1 = store) |
| p1_wdata | input | 64 | Port 1 store data |
| p0_rsp_valid | output | 1 | Port 0 read data valid |
| p0_rsp_data | output | 64 | Port 0 read data |
| p1_rsp_valid | output | 1 | Port 1 read data valid |
| p1_rsp_data | output | 64 | Port 1 read data |
| bank_en | output | 8 | Per-bank access enable |
| bank_we | output | 8 | Per-bank write flag |
| bank_tag | output | 8 | Per-bank port tag of the access |
| bank_idx | output | 80 | Per-bank row index, 10 bits per bank, bank 0 in the low bits |
| bank_wdata | output | 512 | Per-bank write data, 64 bits per bank, bank 0 in the low bits |
| bank_rdata | input | 512 | Per-bank read data, valid one cycle after a read access |

## Verification
The ready outputs and all bank-side outputs are combinational from the current requests and the one-bit collision preference. They are due in the same cycle the requests are driven. The bench applies inputs on the falling edge and compares these outputs a short delay later, before the next rising edge. Read responses are due one cycle after acceptance, because both the bench's bank model and the block's response register update on the same rising edge. The bench therefore keeps the expected response from the previous cycle and compares it at the next falling edge, before it drives the next request. The collision preference is modelled in the bench from its own record of which port 1 request was refused.

// File: rtl/cbank_pkg.sv
package cbank_pkg;
  typedef enum logic {
    PORT_A = 1'b0,
    PORT_B = 1'b1
  } port_id_e;

  localparam int unsigned NUM_PORTS = 2;
endpackage

// File: rtl/cbank_decode.sv
module cbank_decode #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned WORD_LSB = 3,
  localparam int unsigned BANK_W = $clog2(NUM_BANKS),
  localparam int unsigned IDX_W = ADDR_W - WORD_LSB - BANK_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank,
  output logic [IDX_W-1:0]  idx
);
  // Interleave on doubleword: low word bits select the bank.
  assign bank = addr[WORD_LSB +: BANK_W];
  assign idx  = addr[ADDR_W-1 : WORD_LSB+BANK_W];
endmodule

// File: rtl/cbank_pick.sv
module cbank_pick #(
  parameter int unsigned BANK_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        valid,
  input  logic [BANK_W-1:0] bank0,
  input  logic [BANK_W-1:0] bank1,
  output logic [1:0]        ready,
  output logic [1:0]        grant
);
  logic favor_b;
  logic clash;

  assign clash = valid[0] && valid[1] && (bank0 == bank1);

  always_comb begin
    ready = 2'b11;
    if (clash) begin
      if (favor_b) ready[0] = 1'b0;
      else         ready[1] = 1'b0;
    end
  end

  assign grant = valid & ready;

  // Port B gets the next collision after being refused.
  always_ff @(posedge clk) begin
    if (!rst_n) favor_b <= 1'b0;
    else        favor_b <= valid[1] && !ready[1];
  end
endmodule

// File: rtl/cbank_xbar.sv
module cbank_xbar #(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned IDX_W = 10,
  localparam int unsigned BANK_W = $clog2(NUM_BANKS)
) (
  input  logic [1:0]                 grant,
  input  logic [BANK_W-1:0]          bank0,
  input  logic [BANK_W-1:0]          bank1,
  input  logic [IDX_W-1:0]           idx0,
  input  logic [IDX_W-1:0]           idx1,
  input  logic                       we0,
  input  logic                       we1,
  input  logic [DATA_W-1:0]          wd0,
  input  logic [DATA_W-1:0]          wd1,
  output logic [NUM_BANKS-1:0]       bank_en,
  output logic [NUM_BANKS-1:0]       bank_we,
  output logic [NUM_BANKS-1:0]       bank_tag,
  output logic [NUM_BANKS*IDX_W-1:0] bank_idx,
  output logic [NUM_BANKS*DATA_W-1:0] bank_wdata
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit0, hit1;
    assign hit0 = grant[0] && (bank0 == BANK_W'(b));
    assign hit1 = grant[1] && (bank1 == BANK_W'(b));

    always_comb begin
      bank_en[b]                     = hit0 || hit1;
      bank_tag[b]                    = cbank_pkg::PORT_A;
      bank_we[b]                     = we0;
      bank_idx[b*IDX_W +: IDX_W]     = idx0;
      bank_wdata[b*DATA_W +: DATA_W] = wd0;
      if (!hit0 && hit1) begin
        bank_tag[b]                    = cbank_pkg::PORT_B;
        bank_we[b]                     = we1;
        bank_idx[b*IDX_W +: IDX_W]     = idx1;
        bank_wdata[b*DATA_W +: DATA_W] = wd1;
      end
      if (!hit0 && !hit1) bank_we[b] = 1'b0;
    end
  end
endmodule

// File: rtl/cbank_return.sv
module cbank_return #(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned DATA_W = 64,
  localparam int unsigned BANK_W = $clog2(NUM_BANKS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rd_take,
  input  logic [BANK_W-1:0]           rd_bank,
  input  logic [NUM_BANKS*DATA_W-1:0] bank_rdata,
  output logic                        rsp_valid,
  output logic [DATA_W-1:0]           rsp_data
);
  logic [BANK_W-1:0] bank_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      bank_q    <= '0;
    end else begin
      rsp_valid <= rd_take;
      if (rd_take) bank_q <= rd_bank;
    end
  end

  assign rsp_data = bank_rdata[bank_q*DATA_W +: DATA_W];
endmodule

// File: rtl/cbank_dual_arb.sv
module cbank_dual_arb #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned WORD_LSB = 3,
  localparam int unsigned BANK_W = $clog2(NUM_BANKS),
  localparam int unsigned IDX_W = ADDR_W - WORD_LSB - BANK_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        p0_valid,
  output logic                        p0_ready,
  input  logic [ADDR_W-1:0]           p0_addr,
  input  logic                        p0_we,
  input  logic [DATA_W-1:0]           p0_wdata,
  input  logic                        p1_valid,
  output logic                        p1_ready,
  input  logic [ADDR_W-1:0]           p1_addr,
  input  logic                        p1_we,
  input  logic [DATA_W-1:0]           p1_wdata,
  output logic                        p0_rsp_valid,
  output logic [DATA_W-1:0]           p0_rsp_data,
  output logic                        p1_rsp_valid,
  output logic [DATA_W-1:0]           p1_rsp_data,
  output logic [NUM_BANKS-1:0]        bank_en,
  output logic [NUM_BANKS-1:0]        bank_we,
  output logic [NUM_BANKS-1:0]        bank_tag,
  output logic [NUM_BANKS*IDX_W-1:0]  bank_idx,
  output logic [NUM_BANKS*DATA_W-1:0] bank_wdata,
  input  logic [NUM_BANKS*DATA_W-1:0] bank_rdata
);
  localparam int unsigned NP = cbank_pkg::NUM_PORTS;

  logic [ADDR_W-1:0] addr_p [NP];
  logic [BANK_W-1:0] bank_p [NP];
  logic [IDX_W-1:0]  idx_p  [NP];
  logic [NP-1:0]     valid_p, ready_p, grant_p, we_p;
  logic [NP-1:0]     rsp_v;
  logic [DATA_W-1:0] rsp_d  [NP];

  assign addr_p[0] = p0_addr;
  assign addr_p[1] = p1_addr;
  assign valid_p   = {p1_valid, p0_valid};
  assign we_p      = {p1_we, p0_we};

  for (genvar p = 0; p < NP; p++) begin : g_port
    cbank_decode #(
      .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .WORD_LSB(WORD_LSB)
    ) i_dec (
      .addr(addr_p[p]), .bank(bank_p[p]), .idx(idx_p[p])
    );

    cbank_return #(
      .NUM_BANKS(NUM_BANKS), .DATA_W(DATA_W)
    ) i_ret (
      .clk(clk), .rst_n(rst_n),
      .rd_take(grant_p[p] && !we_p[p]),
      .rd_bank(bank_p[p]),
      .bank_rdata(bank_rdata),
      .rsp_valid(rsp_v[p]),
      .rsp_data(rsp_d[p])
    );
  end

  cbank_pick #(.BANK_W(BANK_W)) i_pick (
    .clk(clk), .rst_n(rst_n),
    .valid(valid_p), .bank0(bank_p[0]), .bank1(bank_p[1]),
    .ready(ready_p), .grant(grant_p)
  );

  cbank_xbar #(
    .NUM_BANKS(NUM_BANKS), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) i_xbar (
    .grant(grant_p),
    .bank0(bank_p[0]), .bank1(bank_p[1]),
    .idx0(idx_p[0]), .idx1(idx_p[1]),
    .we0(p0_we), .we1(p1_we),
    .wd0(p0_wdata), .wd1(p1_wdata),
    .bank_en(bank_en), .bank_we(bank_we), .bank_tag(bank_tag),
    .bank_idx(bank_idx), .bank_wdata(bank_wdata)
  );

  assign p0_ready     = ready_p[0];
  assign p1_ready     = ready_p[1];
  assign p0_rsp_valid = rsp_v[0];
  assign p1_rsp_valid = rsp_v[1];
  assign p0_rsp_data  = rsp_d[0];
  assign p1_rsp_data  = rsp_d[1];
endmodule

// File: rtl/cbank_dual_arb_chk.sv
module cbank_dual_arb_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned WORD_LSB = 3,
  localparam int unsigned BANK_W = $clog2(NUM_BANKS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 p0_valid,
  input logic                 p0_ready,
  input logic [ADDR_W-1:0]    p0_addr,
  input logic                 p0_we,
  input logic                 p1_valid,
  input logic                 p1_ready,
  input logic [ADDR_W-1:0]    p1_addr,
  input logic                 p1_we,
  input logic                 p0_rsp_valid,
  input logic                 p1_rsp_valid,
  input logic [NUM_BANKS-1:0] bank_en
);
  logic same_bank, both, b_refused_q, rst_seen;
  logic [1:0] n_take;

  assign same_bank = p0_addr[WORD_LSB +: BANK_W] == p1_addr[WORD_LSB +: BANK_W];
  assign both      = p0_valid && p1_valid;
  assign n_take    = 2'(p0_valid && p0_ready) + 2'(p1_valid && p1_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_refused_q <= 1'b0;
      rst_seen    <= 1'b1;
    end else begin
      b_refused_q <= p1_valid && !p1_ready;
    end
  end

  a_r2_both_granted: assert property (@(posedge clk) disable iff (!rst_n || !rst_seen)
    both && !same_bank |-> p0_ready && p1_ready);

  a_r3_port0_wins: assert property (@(posedge clk) disable iff (!rst_n || !rst_seen)
    both && same_bank && !b_refused_q |-> p0_ready && !p1_ready);

  a_r4_port1_turn: assert property (@(posedge clk) disable iff (!rst_n || !rst_seen)
    both && same_bank && b_refused_q |-> p1_ready && !p0_ready);

  a_r5_enable_count: assert property (@(posedge clk) disable iff (!rst_n || !rst_seen)
    $countones(bank_en) == 32'(n_take));

  a_r7_rsp0_due: assert property (@(posedge clk) disable iff (!rst_n || !rst_seen)
    p0_valid && p0_ready && !p0_we |=> p0_rsp_valid);

  a_r7_rsp0_quiet: assert property (@(posedge clk) disable iff (!rst_n || !rst_seen)
    !(p0_valid && p0_ready && !p0_we) |=> !p0_rsp_valid);

  a_r7_rsp1_due: assert property (@(posedge clk) disable iff (!rst_n || !rst_seen)
    p1_valid && p1_ready && !p1_we |=> p1_rsp_valid);

  a_r7_rsp1_quiet: assert property (@(posedge clk) disable iff (!rst_n || !rst_seen)
    !(p1_valid && p1_ready && !p1_we) |=> !p1_rsp_valid);
endmodule

bind cbank_dual_arb cbank_dual_arb_chk #(
  .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .WORD_LSB(WORD_LSB)
) i_chk (
  .clk(clk), .rst_n(rst_n),
  .p0_valid(p0_valid), .p0_ready(p0_ready), .p0_addr(p0_addr), .p0_we(p0_we),
  .p1_valid(p1_valid), .p1_ready(p1_ready), .p1_addr(p1_addr), .p1_we(p1_we),
  .p0_rsp_valid(p0_rsp_valid), .p1_rsp_valid(p1_rsp_valid),
  .bank_en(bank_en)
);

// File: tb/test_cbank_dual_arb.sv
`timescale 1ns/1ps
module test_cbank_dual_arb;
  localparam int AW = 16, DW = 64, NB = 8, IW = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic p0_valid = 0, p1_valid = 0, p0_we = 0, p1_we = 0;
  logic [AW-1:0] p0_addr = '0, p1_addr = '0;
  logic [DW-1:0] p0_wdata = '0, p1_wdata = '0;
  logic p0_ready, p1_ready, p0_rsp_valid, p1_rsp_valid;
  logic [DW-1:0] p0_rsp_data, p1_rsp_data;
  logic [NB-1:0] bank_en, bank_we, bank_tag;
  logic [NB*IW-1:0] bank_idx;
  logic [NB*DW-1:0] bank_wdata, bank_rdata;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cbank_dual_arb i_cbank_dual_arb (.*);

  // Bank storage: one-cycle read latency.
  logic [DW-1:0] bmem [NB][1024];
  logic [DW-1:0] brd  [NB];
  always @(posedge clk) begin
    for (int b = 0; b < NB; b++)
      if (bank_en[b]) begin
        if (bank_we[b]) bmem[b][bank_idx[b*IW +: IW]] <= bank_wdata[b*DW +: DW];
        else            brd[b] <= bmem[b][bank_idx[b*IW +: IW]];
      end
  end
  always_comb for (int b = 0; b < NB; b++) bank_rdata[b*DW +: DW] = brd[b];

  // Bench-side model state.
  logic [DW-1:0] shadow [NB][1024];
  bit fav1 = 0;
  bit ev0 = 0, ev1 = 0;
  logic [DW-1:0] ed0, ed1;

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int bank_of(logic [AW-1:0] a); return int'(a[5:3]); endfunction
  function automatic int row_of(logic [AW-1:0] a);  return int'(a[15:6]); endfunction

  task automatic step(bit v0, logic [AW-1:0] a0, bit w0, logic [DW-1:0] d0,
                      bit v1, logic [AW-1:0] a1, bit w1, logic [DW-1:0] d1,
                      output bit acc0, output bit acc1);
    bit er0, er1, clash;
    logic [NB-1:0] een;
    @(negedge clk);
    // R7: responses from the previous cycle's reads
    chk("R7 p0 rsp valid", DW'(p0_rsp_valid), DW'(ev0));
    if (ev0) chk("R7 p0 rsp data", p0_rsp_data, ed0);
    chk("R7 p1 rsp valid", DW'(p1_rsp_valid), DW'(ev1));
    if (ev1) chk("R7 p1 rsp data", p1_rsp_data, ed1);
    p0_valid = v0; p0_addr = a0; p0_we = w0; p0_wdata = d0;
    p1_valid = v1; p1_addr = a1; p1_we = w1; p1_wdata = d1;
    #1;
    clash = v0 && v1 && bank_of(a0) == bank_of(a1);
    er0 = !(clash && fav1);
    er1 = !(clash && !fav1);
    chk(clash ? (fav1 ? "R4 p0 ready" : "R3 p0 ready") : "R2 p0 ready", DW'(p0_ready), DW'(er0));
    chk(clash ? (fav1 ? "R4 p1 ready" : "R3 p1 ready") : "R2 p1 ready", DW'(p1_ready), DW'(er1));
    acc0 = v0 && er0;
    acc1 = v1 && er1;
    een = '0;
    if (acc0) een[bank_of(a0)] = 1'b1;
    if (acc1) een[bank_of(a1)] = 1'b1;
    chk("R5 bank enables", DW'(bank_en), DW'(een));
    if (acc0) begin
      chk("R6 p0 we",  DW'(bank_we[bank_of(a0)]), DW'(w0));
      chk("R1 p0 idx", DW'(bank_idx[bank_of(a0)*IW +: IW]), DW'(row_of(a0)));
      chk("R6 p0 tag", DW'(bank_tag[bank_of(a0)]), 0);
      if (w0) chk("R6 p0 wdata", bank_wdata[bank_of(a0)*DW +: DW], d0);
    end
    if (acc1) begin
      chk("R6 p1 we",  DW'(bank_we[bank_of(a1)]), DW'(w1));
      chk("R1 p1 idx", DW'(bank_idx[bank_of(a1)*IW +: IW]), DW'(row_of(a1)));
      chk("R6 p1 tag", DW'(bank_tag[bank_of(a1)]), 1);
      if (w1) chk("R6 p1 wdata", bank_wdata[bank_of(a1)*DW +: DW], d1);
    end
    ev0 = acc0 && !w0;  ed0 = shadow[bank_of(a0)][row_of(a0)];
    ev1 = acc1 && !w1;  ed1 = shadow[bank_of(a1)][row_of(a1)];
    if (acc0 && w0) shadow[bank_of(a0)][row_of(a0)] = d0;
    if (acc1 && w1) shadow[bank_of(a1)][row_of(a1)] = d1;
    fav1 = v1 && !er1;
  endtask

  function automatic logic [AW-1:0] rnd_addr();
    return AW'({$urandom_range(3, 0), 3'($urandom_range(7, 0)), 3'($urandom)});
  endfunction

  initial begin
    bit a0, a1;
    bit v0, v1, w0, w1;
    logic [AW-1:0] x0, x1;
    logic [DW-1:0] d0, d1;
    void'($urandom(32'h5eed_0721));
    for (int b = 0; b < NB; b++)
      for (int r = 0; r < 1024; r++) begin
        bmem[b][r] = DW'(b * 4096 + r);
        shadow[b][r] = DW'(b * 4096 + r);
      end
    for (int b = 0; b < NB; b++) brd[b] = '0;
    repeat (3) @(posedge clk);
    #1;
    // R8: outputs during reset
    chk("R8 p0 rsp valid in reset", DW'(p0_rsp_valid), 0);
    chk("R8 p1 rsp valid in reset", DW'(p1_rsp_valid), 0);
    @(negedge clk); rst_n = 1'b1;
    // R8: no preference after reset: a clash goes to port 0
    step(1, 16'h0028, 0, 0, 1, 16'h0128, 0, 0, a0, a1);
    chk("R8 port0 wins first clash", DW'(a0), 1);
    // R3 then R4: held port 1 wins while port 0 retries the same bank
    step(1, 16'h0068, 1, 64'hAAAA, 1, 16'h0128, 0, 0, a0, a1);
    chk("R4 held port1 accepted", DW'(a1), 1);
    step(1, 16'h0068, 1, 64'hAAAA, 0, 0, 0, 0, a0, a1);
    // R2: different banks, reads both
    step(1, 16'h0068, 0, 0, 1, 16'h0070, 0, 0, a0, a1);
    chk("R2 both accepted", DW'(a0 && a1), 1);
    // R1: low byte bits ignored
    step(1, 16'h006F, 0, 0, 0, 16'h006F, 0, 0, a0, a1);
    // R5: idle cycle
    step(0, 0, 0, 0, 0, 0, 0, 0, a0, a1);

    // Constrained random with valid/ready hold rules
    a0 = 1; a1 = 1;
    for (int i = 0; i < 3000; i++) begin
      if (a0 || !v0) begin
        v0 = ($urandom_range(3, 0) != 0); x0 = rnd_addr(); w0 = $urandom_range(1, 0) != 0;
        d0 = {$urandom, $urandom};
      end
      if (a1 || !v1) begin
        v1 = ($urandom_range(3, 0) != 0); x1 = rnd_addr(); w1 = $urandom_range(1, 0) != 0;
        d1 = {$urandom, $urandom};
      end
      step(v0, x0, w0, d0, v1, x1, w1, d1, a0, a1);
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, a0, a1);
    step(0, 0, 0, 0, 0, 0, 0, 0, a0, a1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule